// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block masters an external asynchronous static-memory bus on behalf of on-chip logic. An internal agent issues one read or write at a time over a valid/ready request port. The block picks one of up to four banks from the top address bits. It then walks the external strobes through a cycle-counted sequence: address set-up, chip-select set-up, the output-enable or write-enable window, chip-select hold, and address hold. Read data comes back on a one-cycle response pulse.

Each bank carries its own timing word, written through a plain register port. The word holds the phase lengths in cycles, the bus width (8 or 16 bits), and a page flag. With the page flag set, a read stays in one chip-select window and returns four items. The later items use a shorter per-item access time. A request snapshots its bank's word when it is accepted, so a later configuration write never disturbs an access already in flight.

Top module: `smc_bank_ctrl`

## Requirements
- R1: The bank is chosen by the top two bits of `req_addr`. During an access only that bank's `mem_cs_n` line goes low, and at most one chip-select is ever low.
- R2: The timing word is {page[26], wide[25], asu[24:21], csu[20:17], acc[16:12], csh[11:8], adh[7:4], pacc[3:0]}. After acceptance, `mem_addr` carries the request address for exactly `asu` cycles before the chip-select falls.
- R3: The chip-select is low for exactly `csu` cycles before the strobe falls. The strobe is never low unless a chip-select is low.
- R4: A non-page read holds `mem_oe_n` low for `acc`+1 cycles. The data on `mem_dq_in` in the last low cycle is returned on `rsp_data` with `rsp_valid` high in the following cycle.
- R5: After the strobe rises, the chip-select stays low for exactly `csh` cycles. After the chip-select rises, the block stays busy for exactly `adh` cycles, with the address held, before `req_ready` returns.
- R6: A page read holds `mem_oe_n` low for (`acc`+1) + 3*max(`pacc`,1) cycles and returns four responses. Item k is read at the address whose two low bits are the start's low bits plus k, modulo 4, with the upper bits unchanged.
- R7: On an 8-bit bank (wide=0), read data has its upper byte forced to zero and written data is driven with its upper byte zero. On a 16-bit bank (wide=1), all 16 bits pass both ways.
- R8: A write uses `mem_we_n` in place of `mem_oe_n` for `acc`+1 cycles. `mem_dq_oe` is high and `mem_dq_out` is stable through the whole write-enable window. A write gives no response, and the page flag has no effect on writes.
- R9: `req_ready` is high only while the bus is quiet (all chip-selects and strobes high). A request held valid during an access is not taken again until the address hold completes.
- R10: A configuration write changes only accesses accepted after it. A write landing in the same cycle that a request to that bank is accepted does not alter that access.
- R11: After reset, `req_ready` is high, all strobes are high, `mem_dq_oe` and `rsp_valid` are low, and every bank's timing word is zero: all phases 0, a one-cycle strobe, 8-bit, no page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing-word write strobe |
| cfg_bank | input | 2 | Bank addressed by the timing-word write |
| cfg_word | input | 27 | Timing word value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Item address; top two bits select the bank |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 16 | Read data |
| mem_addr | output | 20 | External address bus |
| mem_cs_n | output | 4 | Active-low chip-select per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 16 | External write data |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | External read data |

## Verification
A configuration write can land in the same cycle that a request to the same bank is accepted. The bench raises both the write strobe and the request at one clock edge. It then times every phase of that access against the old word and times the next access against the new one. Random runs also hold a request valid through a whole access, to show that it is not taken a second time while the bus is busy.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef struct packed {
    logic       page;
    logic       wide;
    logic [3:0] asu;
    logic [3:0] csu;
    logic [4:0] acc;
    logic [3:0] csh;
    logic [3:0] adh;
    logic [3:0] pacc;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASU, PH_CSU, PH_STRB, PH_CSH, PH_ADH
  } phase_e;

  function automatic phase_e ph_succ(phase_e p);
    case (p)
      PH_ASU:  return PH_CSU;
      PH_CSU:  return PH_STRB;
      PH_STRB: return PH_CSH;
      PH_CSH:  return PH_ADH;
      default: return PH_IDLE;
    endcase
  endfunction

  // Step past phases whose programmed length is zero.
  function automatic phase_e ph_skip(phase_e p, bank_cfg_t c);
    phase_e q;
    q = p;
    if (q == PH_ASU && c.asu == 4'd0) q = PH_CSU;
    if (q == PH_CSU && c.csu == 4'd0) q = PH_STRB;
    if (q == PH_CSH && c.csh == 4'd0) q = PH_ADH;
    if (q == PH_ADH && c.adh == 4'd0) q = PH_IDLE;
    return q;
  endfunction

  function automatic logic [5:0] ph_len(phase_e p, bank_cfg_t c, logic later);
    case (p)
      PH_ASU:  return {2'b00, c.asu};
      PH_CSU:  return {2'b00, c.csu};
      PH_STRB: begin
        if (later) return (c.pacc == 4'd0) ? 6'd1 : {2'b00, c.pacc};
        else       return {1'b0, c.acc} + 6'd1;
      end
      PH_CSH:  return {2'b00, c.csh};
      PH_ADH:  return {2'b00, c.adh};
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bank,
  input  bank_cfg_t     wr_data,
  input  logic [BW-1:0] rd_bank,
  output bank_cfg_t     rd_cfg
);

  bank_cfg_t regs [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) regs[i] <= '0;
    end else if (wr_en && (int'(wr_bank) < NB)) begin
      regs[wr_bank] <= wr_data;
    end
  end

  assign rd_cfg = (int'(rd_bank) < NB) ? regs[rd_bank] : '0;

endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter int DW = 16,
  localparam int HW = DW / 2
) (
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);

  always_comb begin
    if (wide) begin
      dq_out = wdata;
      rdata  = dq_in;
    end else begin
      dq_out = {{(DW-HW){1'b0}}, wdata[HW-1:0]};
      rdata  = {{(DW-HW){1'b0}}, dq_in[HW-1:0]};
    end
  end

endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  bank_cfg_t     sel_cfg,
  output logic [AW-1:0] mem_addr,
  output logic [NB-1:0] cs_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [DW-1:0] wdata_held,
  output logic          wide_held,
  output logic          beat_end
);

  phase_e        phase, ph_n, p_tmp;
  logic [5:0]    cnt, cnt_n;
  logic [1:0]    beat, beat_n;
  logic          adv_lo, take;
  bank_cfg_t     snap;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bank_q, req_bank, bank_n;
  logic [DW-1:0] wdata_q;
  logic          wr_n;
  logic [NB-1:0] cs_nxt;
  logic [NB-1:0] cs_q;
  logic          oe_q, we_q, dqoe_q;

  assign req_bank = req_addr[AW-1 -: BW];
  assign take     = req_valid && (phase == PH_IDLE);
  assign bank_n   = (phase == PH_IDLE) ? req_bank : bank_q;
  assign wr_n     = (phase == PH_IDLE) ? req_write : wr_q;

  always_comb begin
    ph_n   = phase;
    cnt_n  = cnt;
    beat_n = beat;
    adv_lo = 1'b0;
    p_tmp  = PH_IDLE;
    if (phase == PH_IDLE) begin
      if (req_valid) begin
        p_tmp  = ph_skip(PH_ASU, sel_cfg);
        ph_n   = p_tmp;
        cnt_n  = ph_len(p_tmp, sel_cfg, 1'b0) - 6'd1;
        beat_n = 2'd0;
      end
    end else if (cnt != 6'd0) begin
      cnt_n = cnt - 6'd1;
    end else if (phase == PH_STRB && !wr_q && snap.page && beat != 2'd3) begin
      beat_n = beat + 2'd1;
      cnt_n  = ph_len(PH_STRB, snap, 1'b1) - 6'd1;
      adv_lo = 1'b1;
    end else begin
      p_tmp = ph_skip(ph_succ(phase), snap);
      ph_n  = p_tmp;
      cnt_n = (p_tmp == PH_IDLE) ? 6'd0 : ph_len(p_tmp, snap, 1'b0) - 6'd1;
    end
  end

  always_comb begin
    cs_nxt = '1;
    if (ph_n == PH_CSU || ph_n == PH_STRB || ph_n == PH_CSH) begin
      for (int i = 0; i < NB; i++) begin
        if (bank_n == BW'(i)) cs_nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      beat    <= '0;
      snap    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
      cs_q    <= '1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      dqoe_q  <= 1'b0;
    end else begin
      phase <= ph_n;
      cnt   <= cnt_n;
      beat  <= beat_n;
      if (take) begin
        snap    <= sel_cfg;
        wr_q    <= req_write;
        addr_q  <= req_addr;
        bank_q  <= req_bank;
        wdata_q <= req_wdata;
      end else if (adv_lo) begin
        addr_q[1:0] <= addr_q[1:0] + 2'd1;
      end
      cs_q   <= cs_nxt;
      oe_q   <= !(ph_n == PH_STRB && !wr_n);
      we_q   <= !(ph_n == PH_STRB && wr_n);
      dqoe_q <= (ph_n == PH_STRB) && wr_n;
    end
  end

  assign req_ready  = (phase == PH_IDLE);
  assign mem_addr   = addr_q;
  assign cs_n       = cs_q;
  assign oe_n       = oe_q;
  assign we_n       = we_q;
  assign dq_oe      = dqoe_q;
  assign wdata_held = wdata_q;
  assign wide_held  = snap.wide;
  assign beat_end   = (phase == PH_STRB) && (cnt == 6'd0) && !wr_q;

endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
  import smc_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [BW-1:0]    cfg_bank,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    mem_addr,
  output logic [NB-1:0]    mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);

  bank_cfg_t     sel_cfg;
  logic [DW-1:0] wdata_held, rdata;
  logic          wide_held, beat_end;

  smc_cfg_regs #(.NB(NB)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_bank (cfg_bank),
    .wr_data (bank_cfg_t'(cfg_word)),
    .rd_bank (req_addr[AW-1 -: BW]),
    .rd_cfg  (sel_cfg)
  );

  smc_seq #(.NB(NB), .AW(AW), .DW(DW)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sel_cfg    (sel_cfg),
    .mem_addr   (mem_addr),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe),
    .wdata_held (wdata_held),
    .wide_held  (wide_held),
    .beat_end   (beat_end)
  );

  smc_datapath #(.DW(DW)) i_dp (
    .wide   (wide_held),
    .wdata  (wdata_held),
    .dq_in  (mem_dq_in),
    .dq_out (mem_dq_out),
    .rdata  (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= beat_end;
      if (beat_end) rsp_data <= rdata;
    end
  end

endmodule

// File: rtl/smc_bank_ctrl_chk.sv
module smc_bank_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NB-1:0] mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic          rsp_valid,
  input logic          req_ready
);

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n)); // R1

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R3

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R8

  AST_DQ_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe); // R8

  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!mem_oe_n)); // R4

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n)); // R9

endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk #(.NB(NB)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_valid (rsp_valid),
  .req_ready (req_ready)
);

// File: tb/test_smc_bank_ctrl.sv
module test_smc_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [26:0] cfg_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [19:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  logic [26:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(logic [19:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ {4'h0, a[19:16]} ^ {a[1:0], a[7:2]}};
  endfunction

  // External memory: drives a pattern of the address while output-enable is low.
  assign mem_dq_in = mem_oe_n ? 16'hFFFF : pat(mem_addr);

  smc_bank_ctrl i_smc_bank_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input logic pg, input logic wd, input int asu, input int csu,
                                     input int acc, input int csh, input int adh, input int pacc);
    return {pg, wd, 4'(asu), 4'(csu), 5'(acc), 4'(csh), 4'(adh), 4'(pacc)};
  endfunction

  task automatic cfg_write(input logic [1:0] b, input logic [26:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_bank = b; cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    model[b] = w;
  endtask

  // One access, timed against the word ec. Optionally writes uw to the same bank in the
  // acceptance cycle (R10) and optionally keeps req_valid high throughout (R9).
  task automatic access(input logic wr, input logic [19:0] a, input logic [15:0] wd,
                        input logic [26:0] ec, input logic upd, input logic [26:0] uw,
                        input logic hold);
    int cnt [5];
    int st, nrsp, guard;
    logic [1:0] b;
    logic csb, strb, bad_cs, bad_strb, bad_dq, bad_addr, rebus;
    logic [15:0] got [4];
    int exp_str, exp_rsp, pa;
    b = a[19:18];
    pa = (ec[3:0] == 4'd0) ? 1 : int'(ec[3:0]);
    exp_str = int'(ec[16:12]) + 1 + ((ec[26] && !wr) ? 3 * pa : 0);
    exp_rsp = wr ? 0 : (ec[26] ? 4 : 1);
    for (int i = 0; i < 5; i++) cnt[i] = 0;
    st = 0; nrsp = 0; guard = 0;
    bad_cs = 0; bad_strb = 0; bad_dq = 0; bad_addr = 0; rebus = 0;
    @(negedge clk);
    check(req_ready, "R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    if (upd) begin cfg_wr = 1'b1; cfg_bank = b; cfg_word = uw; end
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    cfg_wr = 1'b0;
    if (upd) model[b] = uw;
    forever begin
      if (rsp_valid && nrsp < 4) begin got[nrsp] = rsp_data; nrsp++; end
      if (req_ready || guard > 400) break;
      guard++;
      csb  = !mem_cs_n[b];
      strb = wr ? !mem_we_n : !mem_oe_n;
      for (int i = 0; i < 4; i++) if (i != int'(b) && !mem_cs_n[i]) bad_cs = 1;
      if (wr ? !mem_oe_n : !mem_we_n) bad_strb = 1;
      if (mem_addr[19:2] != a[19:2]) bad_addr = 1;
      if (!ec[26] || wr) if (mem_addr != a) bad_addr = 1;
      if (wr && strb && (!mem_dq_oe || mem_dq_out !=
          (ec[25] ? wd : {8'h00, wd[7:0]}))) bad_dq = 1;
      if (st == 4 && csb) rebus = 1;
      if (st == 0 && csb) st = 1;
      if (st == 1 && strb) st = 2;
      if (st == 2 && !strb) st = 3;
      if (st == 3 && !csb) st = 4;
      cnt[st]++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(guard <= 400, "R9 access completes", guard, 400);
    check(cnt[0] == int'(ec[24:21]), "R2 address set-up cycles", cnt[0], int'(ec[24:21]));
    check(cnt[1] == int'(ec[20:17]), "R3 chip-select set-up cycles", cnt[1], int'(ec[20:17]));
    check(cnt[2] == exp_str, wr ? "R8 write strobe cycles" : (ec[26] ? "R6 page strobe cycles"
          : "R4 read strobe cycles"), cnt[2], exp_str);
    check(cnt[3] == int'(ec[11:8]), "R5 chip-select hold cycles", cnt[3], int'(ec[11:8]));
    check(cnt[4] == int'(ec[7:4]), "R5 address hold cycles", cnt[4], int'(ec[7:4]));
    check(!bad_cs, "R1 only selected bank", int'(mem_cs_n), 0);
    check(!bad_strb && !rebus, "R9 single strobe kind, no re-entry", int'(rebus), 0);
    check(!bad_addr, "R6 address bus content", int'(mem_addr), int'(a));
    if (wr) check(!bad_dq, "R7 R8 write data window", int'(mem_dq_out), int'(wd));
    check(nrsp == exp_rsp, "R6 R8 response count", nrsp, exp_rsp);
    for (int k = 0; k < 4; k++) begin
      if (k < exp_rsp && k < nrsp) begin
        logic [19:0] ka;
        logic [15:0] ev;
        ka = {a[19:2], a[1:0] + 2'(k)};
        ev = ec[25] ? pat(ka) : {8'h00, pat(ka)[7:0]};
        check(got[k] == ev, "R4 R6 R7 read data", int'(got[k]), int'(ev));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned sd;
    logic [26:0] w0, w1;
    sd = $urandom(32'd20240611);
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
    check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R11 strobes idle",
          int'({mem_cs_n, mem_oe_n, mem_we_n}), 'h3F);
    check(!mem_dq_oe && !rsp_valid, "R11 no drive, no response",
          int'({mem_dq_oe, rsp_valid}), 0);
    // R11 default word: zero phases, 8-bit, single item
    access(1'b0, 20'h8_0123, 16'h0, model[2], 1'b0, '0, 1'b0);
    access(1'b1, 20'h8_0040, 16'hBEEF, model[2], 1'b0, '0, 1'b0);
    // Maximum values, 16-bit page read with minimum later-item time (R6, R4)
    cfg_write(2'd1, mk(1, 1, 15, 15, 31, 15, 15, 0));
    access(1'b0, 20'h4_1232, 16'h0, model[1], 1'b0, '0, 1'b0);
    // Page read with wrap of low bits and long later items (R6)
    cfg_write(2'd1, mk(1, 1, 0, 2, 3, 0, 1, 15));
    access(1'b0, 20'h4_00F3, 16'h0, model[1], 1'b0, '0, 1'b0);
    // Page flag ignored for writes (R8)
    access(1'b1, 20'h4_0007, 16'hA55A, model[1], 1'b0, '0, 1'b0);
    // 8-bit bank write and read (R7)
    cfg_write(2'd3, mk(1, 0, 1, 0, 2, 1, 0, 1));
    access(1'b1, 20'hC_0100, 16'h9C3D, model[3], 1'b0, '0, 1'b0);
    access(1'b0, 20'hC_0101, 16'h0, model[3], 1'b0, '0, 1'b0);
    // R10 configuration write in the acceptance cycle: old word applies, new one next
    w0 = mk(0, 1, 3, 2, 4, 1, 2, 0);
    w1 = mk(0, 0, 0, 5, 1, 3, 0, 0);
    cfg_write(2'd0, w0);
    access(1'b0, 20'h0_0456, 16'h0, w0, 1'b1, w1, 1'b0);
    access(1'b0, 20'h0_0457, 16'h0, model[0], 1'b0, '0, 1'b0);
    // Random mix; request sometimes held valid through the access (R9)
    for (int n = 0; n < 160; n++) begin
      logic [1:0] rb;
      logic [26:0] rw;
      rb = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        rw = 27'($urandom);
        if ($urandom_range(0, 3) == 0) rw[24:21] = '0;
        if ($urandom_range(0, 3) == 0) rw[20:17] = '0;
        if ($urandom_range(0, 3) == 0) rw[16:12] = '0;
        if ($urandom_range(0, 3) == 0) rw[11:8] = '0;
        if ($urandom_range(0, 3) == 0) rw[7:4] = '0;
        if ($urandom_range(0, 3) == 0) rw[3:0] = '0;
        cfg_write(rb, rw);
      end
      access(1'($urandom_range(0, 1)), {rb, 18'($urandom)}, 16'($urandom), model[rb],
             1'b0, '0, 1'($urandom_range(0, 1)));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule